// File: doc/BRIEF.md
# Low-Power Freeze Mode Controller

This block decides when a logic core may drop into an ultra-low-power freeze state and when it must come back. It watches an active-low freeze request pin and an active-high request raised by user logic. A freeze-active flag and a clock-gate enable tell the rest of the chip that the clocks are stopped. Registers and memories keep their contents through freeze, because the controller only removes the clock and never resets the core.

A policy input picks one of two entry rules. Under the pin-only policy, the pin alone decides entry and exit. Under the joint policy, the pin and the user request must both be asserted, and dropping either one ends the freeze. The pin passes through a two-flop synchroniser and a glitch filter. The user request and the policy input pass through a two-flop synchroniser only. After a valid request, the controller waits a fixed settle time (1 µs by default) before it freezes. If the request is withdrawn during that wait, the entry is cancelled.

Top module: `freeze_ctrl`

## Requirements
- R1: `frz_pin_n` is active low: logic 0 requests freeze and logic 1 withdraws it. It passes through two synchroniser flops before the glitch filter.
- R2: A new pin level is accepted only after it has been sampled on FILT_LEN (default 4) consecutive clocks. A shorter low pulse never starts an entry, and a shorter high pulse never ends a freeze.
- R3: With `policy_sel` = 0 (pin-only), `user_frz_req` is ignored. Toggling it changes neither `frozen` nor `clk_en`.
- R4: With `policy_sel` = 1 (joint), freeze is entered only while the filtered pin request is asserted and `user_frz_req` = 1 (active high). Deasserting either one starts the exit.
- R5: `frozen` rises exactly SETTLE_CYC = CLK_MHZ*SETTLE_US clocks (default 50) after the controller leaves its run state. From a pin change this is 7+SETTLE_CYC clocks in total, and from a user-request rise it is 3+SETTLE_CYC clocks.
- R6: If the request is withdrawn during the settle wait, the controller returns to run and `frozen` never asserts.
- R7: Freeze ends when the request is withdrawn. `frozen` falls 7 clocks after the pin returns high, and 3 clocks after `user_frz_req` falls under the joint policy.
- R8: `clk_en` is always the complement of `frozen`, so the clock gate is closed exactly while frozen.
- R9: Asserting `rst_n` (low) forces `frozen` = 0 and `clk_en` = 1 at once, without waiting for a clock. Release is synchronised and takes effect after two clock edges.
- R10: `user_frz_req` and `policy_sel` each pass through two synchroniser flops before the policy logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frz_pin_n | input | 1 | Freeze request pin, active low |
| user_frz_req | input | 1 | Freeze request from user logic, active high |
| policy_sel | input | 1 | 0: pin-only policy, 1: pin and user request jointly |
| frozen | output | 1 | High while the core is frozen |
| clk_en | output | 1 | Clock-gate enable for the core, low while frozen |

## Verification
The controller is driven with these input patterns:
- clean pin requests under the pin-only policy, which confirm the exact entry and exit latencies;
- the same requests while the user input toggles, which show that it is ignored;
- pin pulses one clock short of the filter length, in both directions, which separate glitch rejection from real transitions;
- pin-only requests under the joint policy, which must not freeze, and user-request rises and falls, which give the shorter user-path latencies;
- requests withdrawn mid-wait, which expose a missing cancel;
- a reset asserted while frozen, which checks the asynchronous return to run.

A behavioural model tracks the expected state every clock.

// File: rtl/frz_pkg.sv
package frz_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_WAIT   = 2'd1,
    ST_FROZEN = 2'd2
  } frz_state_e;

  typedef enum logic {
    POL_PIN_ONLY  = 1'b0,
    POL_PIN_USER  = 1'b1
  } frz_policy_e;

endpackage

// File: rtl/frz_rst_sync.sv
module frz_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stg_q <= 2'b00;
    end else begin
      stg_q <= {stg_q[0], 1'b1};
    end
  end

  assign rst_n_out = stg_q[1];

endmodule

// File: rtl/frz_sync.sv
module frz_sync #(
  parameter int              WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= RST_VAL[g];
        stab_q[g] <= RST_VAL[g];
      end else begin
        meta_q[g] <= d_in[g];
        stab_q[g] <= meta_q[g];
      end
    end
  end

  assign d_out = stab_q;

endmodule

// File: rtl/frz_glitch_filter.sv
module frz_glitch_filter #(
  parameter int   FILT_LEN = 4,
  parameter logic RST_LVL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic filt_out
);

  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          lvl_q;
  logic          lvl_d;
  logic          lvl_ld;
  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;
  logic          run_en;
  logic          differs;

  assign differs = (raw_in != lvl_q);

  always_comb begin
    lvl_d  = raw_in;
    lvl_ld = differs && (run_q == LAST);
    run_en = differs || (run_q != '0);
    if (!differs || lvl_ld) begin
      run_d = '0;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= RST_LVL;
    end else if (lvl_ld) begin
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

  assign filt_out = lvl_q;

endmodule

// File: rtl/frz_fsm.sv
module frz_fsm
  import frz_pkg::*;
#(
  parameter int SETTLE_CYC = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_req,
  input  logic       user_req,
  input  logic       policy,
  output logic       frozen,
  output logic       clk_en,
  output frz_state_e state_o
);

  localparam int CW = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  frz_state_e    state_q;
  frz_state_e    state_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          req_ok;

  always_comb begin
    if (frz_policy_e'(policy) == POL_PIN_ONLY) begin
      req_ok = pin_req;
    end else begin
      req_ok = pin_req && user_req;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (req_ok) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (!req_ok) begin
          state_d = ST_RUN;
        end else if (cnt_q == LAST) begin
          state_d = ST_FROZEN;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_FROZEN: begin
        if (!req_ok) begin
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign frozen  = (state_q == ST_FROZEN);
  assign clk_en  = (state_q != ST_FROZEN);
  assign state_o = state_q;

endmodule

// File: rtl/freeze_ctrl.sv
module freeze_ctrl
  import frz_pkg::*;
#(
  parameter int CLK_MHZ   = 50,
  parameter int SETTLE_US = 1,
  parameter int FILT_LEN  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frz_pin_n,
  input  logic user_frz_req,
  input  logic policy_sel,
  output logic frozen,
  output logic clk_en
);

  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;

  logic       rst_core_n;
  logic       pin_sync;
  logic       pin_filt;
  logic [1:0] ctl_sync;
  logic       user_sync;
  logic       pol_sync;
  frz_state_e fsm_state;

  frz_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  frz_sync #(
    .WIDTH   (1),
    .RST_VAL (1'b1)
  ) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_in  (frz_pin_n),
    .d_out (pin_sync)
  );

  frz_sync #(
    .WIDTH   (2),
    .RST_VAL (2'b00)
  ) u_ctl_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_in  ({policy_sel, user_frz_req}),
    .d_out (ctl_sync)
  );

  assign user_sync = ctl_sync[0];
  assign pol_sync  = ctl_sync[1];

  frz_glitch_filter #(
    .FILT_LEN (FILT_LEN),
    .RST_LVL  (1'b1)
  ) u_pin_filt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .raw_in   (pin_sync),
    .filt_out (pin_filt)
  );

  frz_fsm #(
    .SETTLE_CYC (SETTLE_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .pin_req  (~pin_filt),
    .user_req (user_sync),
    .policy   (pol_sync),
    .frozen   (frozen),
    .clk_en   (clk_en),
    .state_o  (fsm_state)
  );

endmodule

// File: rtl/frz_checker.sv
module frz_checker
  import frz_pkg::*;
#(
  parameter int FILT_LEN   = 4,
  parameter int SETTLE_CYC = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       frozen,
  input logic       clk_en,
  input logic       pin_sync,
  input logic       pin_filt,
  input logic       user_sync,
  input logic       pol_sync,
  input frz_state_e state
);

  localparam int MW = $clog2(FILT_LEN + 1) + 1;
  localparam int WW = $clog2(SETTLE_CYC + 2) + 1;

  logic [MW-1:0] mis_run;
  logic [WW-1:0] wait_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mis_run <= '0;
    end else if (pin_sync == pin_filt) begin
      mis_run <= '0;
    end else if (mis_run < MW'(FILT_LEN)) begin
      mis_run <= mis_run + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_run <= '0;
    end else if (state == ST_WAIT) begin
      wait_run <= wait_run + 1'b1;
    end else begin
      wait_run <= '0;
    end
  end

  // R8
  assert_gate_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en != frozen);

  // R5
  assert_settle_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> wait_run == WW'(SETTLE_CYC));

  // R2
  assert_filter_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_filt != $past(pin_filt)) |-> $past(mis_run) >= MW'(FILT_LEN - 1));

  // R7
  assert_exit_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FROZEN && pin_filt) |=> !frozen);

  // R4
  assert_joint_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frozen) && $past(pol_sync)) |-> ($past(user_sync) && !$past(pin_filt)));

  // R6
  assert_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && pin_filt) |=> state == ST_RUN);

endmodule

bind freeze_ctrl frz_checker #(
  .FILT_LEN   (FILT_LEN),
  .SETTLE_CYC (SETTLE_CYC)
) u_frz_checker (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .frozen    (frozen),
  .clk_en    (clk_en),
  .pin_sync  (pin_sync),
  .pin_filt  (pin_filt),
  .user_sync (user_sync),
  .pol_sync  (pol_sync),
  .state     (fsm_state)
);

// File: tb/tb_freeze_ctrl.sv
`timescale 1ns/1ps
module tb_freeze_ctrl;

  localparam int SET = 50;
  localparam int FL  = 4;

  logic clk;
  logic rst_n;
  logic frz_pin_n;
  logic user_frz_req;
  logic policy_sel;
  logic frozen;
  logic clk_en;

  int checks;
  int fails;
  string cur_req;
  bit saw_frz;
  bit saw_run;

  freeze_ctrl dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frz_pin_n    (frz_pin_n),
    .user_frz_req (user_frz_req),
    .policy_sel   (policy_sel),
    .frozen       (frozen),
    .clk_en       (clk_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference model
  int m_rcnt;
  bit m_p1, m_p2, m_u1, m_u2, m_s1, m_s2, m_filt;
  int m_run, m_st, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    bit req;
    if (!rst_n) begin
      m_rcnt = 0; m_p1 = 1; m_p2 = 1; m_u1 = 0; m_u2 = 0;
      m_s1 = 0; m_s2 = 0; m_filt = 1; m_run = 0; m_st = 0; m_cnt = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      req = !m_filt && (!m_s2 || m_u2);
      if (m_st == 0) begin
        if (req) begin m_st = 1; m_cnt = 0; end
      end else if (m_st == 1) begin
        if (!req) m_st = 0;
        else if (m_cnt == SET - 1) m_st = 2;
        else m_cnt++;
      end else if (!req) begin
        m_st = 0;
      end
      if (m_p2 != m_filt) begin
        if (m_run == FL - 1) begin m_filt = m_p2; m_run = 0; end
        else m_run++;
      end else begin
        m_run = 0;
      end
      m_p2 = m_p1; m_p1 = frz_pin_n;
      m_u2 = m_u1; m_u1 = user_frz_req;
      m_s2 = m_s1; m_s1 = policy_sel;
    end
  end

  always @(negedge clk) begin
    bit exp_f;
    exp_f = (m_st == 2);
    checks++;
    if (frozen !== exp_f || clk_en !== !exp_f) begin
      fails++;
      $display("FAIL %s model: frozen=%b clk_en=%b expected frozen=%b clk_en=%b",
               cur_req, frozen, clk_en, exp_f, !exp_f);
    end
    if (frozen === 1'b1) saw_frz = 1;
    if (frozen === 1'b0) saw_run = 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic pin, input logic usr, input logic pol);
    @(posedge clk); #2;
    frz_pin_n = pin; user_frz_req = usr; policy_sel = pol;
  endtask

  task automatic measure(input logic want, output int n);
    n = 0;
    do begin
      @(posedge clk); n++; #5;
    end while (frozen !== want && n < 300);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    checks = 0; fails = 0; cur_req = "R9";
    rst_n = 1'b0; frz_pin_n = 1'b1; user_frz_req = 1'b0; policy_sel = 1'b0;
    #1;
    chk(frozen === 1'b0 && clk_en === 1'b1, "R9 reset state", frozen, 0);
    idle(3);
    rst_n = 1'b1;
    idle(6);

    // pin-only entry latency
    cur_req = "R1/R5";
    drive(1'b0, 1'b0, 1'b0);
    measure(1'b1, n);
    chk(n == 7 + SET, "R1/R5 pin entry latency", n, 7 + SET);

    // user input ignored in pin-only policy
    cur_req = "R3";
    saw_run = 0;
    repeat (5) begin
      drive(1'b0, 1'b1, 1'b0); idle(3);
      drive(1'b0, 1'b0, 1'b0); idle(3);
    end
    idle(4);
    chk(!saw_run && frozen === 1'b1, "R3 user toggling ignored", saw_run, 0);

    // high glitch while frozen
    cur_req = "R2";
    saw_run = 0;
    drive(1'b1, 1'b0, 1'b0); idle(FL - 2);
    drive(1'b0, 1'b0, 1'b0); idle(20);
    chk(!saw_run, "R2 short high pulse keeps freeze", saw_run, 0);

    // exit on pin release
    cur_req = "R7";
    drive(1'b1, 1'b0, 1'b0);
    measure(1'b0, n);
    chk(n == 7, "R7 pin exit latency", n, 7);

    // low glitch from run
    cur_req = "R2";
    idle(10);
    saw_frz = 0;
    drive(1'b0, 1'b0, 1'b0); idle(FL - 2);
    drive(1'b1, 1'b0, 1'b0); idle(SET + 30);
    chk(!saw_frz, "R2 short low pulse no entry", saw_frz, 0);

    // cancel during settle
    cur_req = "R6";
    saw_frz = 0;
    drive(1'b0, 1'b0, 1'b0); idle(7 + SET / 2);
    drive(1'b1, 1'b0, 1'b0); idle(SET + 20);
    chk(!saw_frz && frozen === 1'b0, "R6 withdrawn during settle", saw_frz, 0);

    // joint policy: pin alone is not enough
    cur_req = "R4";
    drive(1'b1, 1'b0, 1'b1); idle(5);
    saw_frz = 0;
    drive(1'b0, 1'b0, 1'b1); idle(SET + 30);
    chk(!saw_frz, "R4 pin alone under joint policy", saw_frz, 0);

    cur_req = "R4/R10";
    drive(1'b0, 1'b1, 1'b1);
    measure(1'b1, n);
    chk(n == 3 + SET, "R4/R10 user entry latency", n, 3 + SET);

    cur_req = "R7";
    drive(1'b0, 1'b0, 1'b1);
    measure(1'b0, n);
    chk(n == 3, "R7 user exit latency", n, 3);

    cur_req = "R4";
    drive(1'b0, 1'b1, 1'b1);
    measure(1'b1, n);
    chk(n == 3 + SET, "R4 re-entry", n, 3 + SET);
    drive(1'b1, 1'b1, 1'b1);
    measure(1'b0, n);
    chk(n == 7, "R4/R7 pin exit under joint policy", n, 7);

    // cancel by user withdrawal
    cur_req = "R6";
    idle(10);
    saw_frz = 0;
    drive(1'b0, 1'b1, 1'b1); idle(SET / 2);
    drive(1'b0, 1'b0, 1'b1); idle(SET + 20);
    chk(!saw_frz, "R6 user withdrawn during settle", saw_frz, 0);

    // async reset while frozen
    cur_req = "R9";
    drive(1'b0, 1'b0, 1'b0);
    measure(1'b1, n);
    chk(frozen === 1'b1, "R9 frozen before reset", frozen, 1);
    @(posedge clk); #2;
    rst_n = 1'b0;
    #1;
    chk(frozen === 1'b0 && clk_en === 1'b1, "R9 async reset clears freeze", frozen, 0);
    frz_pin_n = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(10);
    chk(frozen === 1'b0 && clk_en === 1'b1, "R8/R9 run after reset", clk_en, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule